// File: doc/BRIEF.md
# Display Modeline Validation Clamp

This block accepts a requested display modeline and returns a version that a raster timing generator with fixed-width fields can actually hold. The horizontal side carries display end, sync start, sync end and total in pixels. The vertical side carries the same four points in lines. A one-cycle valid strobe captures the request. Two rising edges later the eight corrected values appear on the outputs, and a done flag is high for that one cycle. The outputs keep their values until the next strobe.

The corrections form a chain in which each step uses the result of the step before it. Horizontal values are first rounded down to a multiple of 8. Each value is then capped at the largest number its register field can express. The display end is forced into a sane range. The total is pulled into a blanking window measured from the display end. Finally the sync pulse is moved out of the active area and shortened to the longest pulse the field can encode. Every step works in 16-bit unsigned arithmetic. A subtraction that would go negative stops at zero instead of wrapping.

Top module: `modeline_clamp`

## Requirements
- R1: Every horizontal output (display end, sync start, sync end, total) has its low three bits at zero, because each horizontal input has those bits cleared before any other step.
- R2: Horizontal display end output = the aligned input, first capped at 4072, then raised to at least 640, then lowered to at most 2048.
- R3: Horizontal total output = the aligned input capped at 4128, then raised to at least display end + 80, then lowered to at most display end + 1016, using the corrected display end.
- R4: Horizontal sync start is capped at 4080 and sync end at 4088. Sync end is then lowered to at most total - 8. Next, sync start is raised to at least display end + 8. Last, sync end is lowered to at most sync start + 248.
- R5: Vertical display end output = the input capped at 2045, then raised to at least 480, then lowered to at most 1536.
- R6: Vertical total output = the input capped at 2049, then raised to at least display end + 3, then lowered to at most display end + 255.
- R7: Vertical sync start is capped at 2046 and sync end at 2047. Sync end is then lowered to at most total - 1. Next, sync start is raised to at least display end + 1. Last, sync end is lowered to at most sync start + 15.
- R8: When valid is high at one rising edge, done is low after that edge, high after the next rising edge, and low again one edge later. The outputs for that request are present while done is high.
- R9: While no strobe is in flight, the outputs keep their values whatever the data inputs do.
- R10: During and after reset, all eight outputs read zero and done reads low until a strobe completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe, one cycle |
| h_disp_i | input | 16 | Requested horizontal display end, pixels |
| h_ss_i | input | 16 | Requested horizontal sync start, pixels |
| h_se_i | input | 16 | Requested horizontal sync end, pixels |
| h_tot_i | input | 16 | Requested horizontal total, pixels |
| v_disp_i | input | 16 | Requested vertical display end, lines |
| v_ss_i | input | 16 | Requested vertical sync start, lines |
| v_se_i | input | 16 | Requested vertical sync end, lines |
| v_tot_i | input | 16 | Requested vertical total, lines |
| h_disp_o | output | 16 | Corrected horizontal display end |
| h_ss_o | output | 16 | Corrected horizontal sync start |
| h_se_o | output | 16 | Corrected horizontal sync end |
| h_tot_o | output | 16 | Corrected horizontal total |
| v_disp_o | output | 16 | Corrected vertical display end |
| v_ss_o | output | 16 | Corrected vertical sync start |
| v_se_o | output | 16 | Corrected vertical sync end |
| v_tot_o | output | 16 | Corrected vertical total |
| done_o | output | 1 | High for one cycle when the corrected values appear |

## Verification
The clamp chain is driven with three kinds of input:
- Uniformly random 16-bit words. These mostly hit the field caps and the upper display limit, and they show whether each cap is applied before the range steps rather than after them.
- Near-legal modelines built around a random display end. These keep the display, total and sync points close together, so the steps that depend on one another decide the result. This is where a clamp applied in the wrong order, or one that reads a stale uncorrected value, gives a result that differs from the expected one.
- Directed corners: all zeros, all ones, unaligned widths, overlong sync pulses, a sync pulse placed inside the active area, and an ordinary legal mode that must pass through unchanged.

Between requests the data inputs are scrambled, to show that the outputs hold.

// File: rtl/mlc_pkg.sv
`timescale 1ns/1ps
package mlc_pkg;

   parameter int unsigned MLC_W = 16;

   typedef logic [MLC_W-1:0] mlc_val_t;

   // lower v to lim when above it
   function automatic mlc_val_t cap_hi(input mlc_val_t v, input mlc_val_t lim);
      return (v > lim) ? lim : v;
   endfunction

   // raise v to lim when below it
   function automatic mlc_val_t cap_lo(input mlc_val_t v, input mlc_val_t lim);
      return (v < lim) ? lim : v;
   endfunction

   // a - b, stopping at zero
   function automatic mlc_val_t sat_sub(input mlc_val_t a, input mlc_val_t b);
      return (a > b) ? (a - b) : '0;
   endfunction

endpackage

// File: rtl/mlc_strobe_pipe.sv
`timescale 1ns/1ps
module mlc_strobe_pipe #(
   parameter int unsigned LAT = 2
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           strobe_i,
   output logic [LAT-1:0] taps_o
);

   if (LAT < 1) begin : gen_bad_lat
      $error("mlc_strobe_pipe: LAT must be at least 1");
   end

   if (LAT == 1) begin : gen_single
      always_ff @(posedge clk_i) begin
         if (!rst_ni) taps_o <= '0;
         else         taps_o <= strobe_i;
      end
   end else begin : gen_shift
      always_ff @(posedge clk_i) begin
         if (!rst_ni) taps_o <= '0;
         else         taps_o <= {taps_o[LAT-2:0], strobe_i};
      end
   end

endmodule

// File: rtl/mlc_axis_clamp.sv
`timescale 1ns/1ps
module mlc_axis_clamp
   import mlc_pkg::*;
#(
   parameter int unsigned ALIGN_BITS   = 3,
   parameter int unsigned DISP_CAP     = 4072,
   parameter int unsigned SS_CAP       = 4080,
   parameter int unsigned SE_CAP       = 4088,
   parameter int unsigned TOT_CAP      = 4128,
   parameter int unsigned DISP_MIN     = 640,
   parameter int unsigned DISP_MAX     = 2048,
   parameter int unsigned TOT_MIN_GAP  = 80,
   parameter int unsigned TOT_MAX_GAP  = 1016,
   parameter int unsigned SE_TOT_GAP   = 8,
   parameter int unsigned SS_DISP_GAP  = 8,
   parameter int unsigned SYNC_MAX_LEN = 248
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     load1_i,
   input  logic     load2_i,
   input  mlc_val_t disp_i,
   input  mlc_val_t ss_i,
   input  mlc_val_t se_i,
   input  mlc_val_t tot_i,
   output mlc_val_t disp_o,
   output mlc_val_t ss_o,
   output mlc_val_t se_o,
   output mlc_val_t tot_o
);

   localparam mlc_val_t LOW_MASK  = mlc_val_t'((64'd1 << ALIGN_BITS) - 64'd1);
   localparam mlc_val_t ALIGN_MSK = ~LOW_MASK;
   localparam mlc_val_t K_DCAP    = mlc_val_t'(DISP_CAP);
   localparam mlc_val_t K_SSCAP   = mlc_val_t'(SS_CAP);
   localparam mlc_val_t K_SECAP   = mlc_val_t'(SE_CAP);
   localparam mlc_val_t K_TCAP    = mlc_val_t'(TOT_CAP);
   localparam mlc_val_t K_DMIN    = mlc_val_t'(DISP_MIN);
   localparam mlc_val_t K_DMAX    = mlc_val_t'(DISP_MAX);
   localparam mlc_val_t K_TLO     = mlc_val_t'(TOT_MIN_GAP);
   localparam mlc_val_t K_THI     = mlc_val_t'(TOT_MAX_GAP);
   localparam mlc_val_t K_SEGAP   = mlc_val_t'(SE_TOT_GAP);
   localparam mlc_val_t K_SSGAP   = mlc_val_t'(SS_DISP_GAP);
   localparam mlc_val_t K_SLEN    = mlc_val_t'(SYNC_MAX_LEN);

   // elaboration-time parameter checks
   if (ALIGN_BITS >= MLC_W) begin : gen_bad_align
      $error("mlc_axis_clamp: ALIGN_BITS too wide");
   end
   if (DISP_MIN > DISP_MAX) begin : gen_bad_range
      $error("mlc_axis_clamp: DISP_MIN above DISP_MAX");
   end
   if (DISP_MAX + TOT_MAX_GAP + SYNC_MAX_LEN >= (64'd1 << MLC_W)) begin : gen_bad_span
      $error("mlc_axis_clamp: limits overflow the value width");
   end

   // ---------------- stage 1: alignment, caps, display range, total window
   mlc_val_t a_disp, a_ss, a_se, a_tot;

   if (ALIGN_BITS > 0) begin : gen_align
      assign a_disp = disp_i & ALIGN_MSK;
      assign a_ss   = ss_i   & ALIGN_MSK;
      assign a_se   = se_i   & ALIGN_MSK;
      assign a_tot  = tot_i  & ALIGN_MSK;
   end else begin : gen_noalign
      assign a_disp = disp_i;
      assign a_ss   = ss_i;
      assign a_se   = se_i;
      assign a_tot  = tot_i;
   end

   mlc_val_t c_disp, c_ss, c_se, c_tot;
   mlc_val_t r_disp, t_lo, t_hi;

   always_comb begin
      c_disp = cap_hi(a_disp, K_DCAP);
      c_ss   = cap_hi(a_ss,   K_SSCAP);
      c_se   = cap_hi(a_se,   K_SECAP);
      c_tot  = cap_hi(a_tot,  K_TCAP);
      r_disp = cap_hi(cap_lo(c_disp, K_DMIN), K_DMAX);
      t_lo   = cap_lo(c_tot, r_disp + K_TLO);
      t_hi   = cap_hi(t_lo,  r_disp + K_THI);
   end

   mlc_val_t q_disp, q_ss, q_se, q_tot;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q_disp <= '0;
         q_ss   <= '0;
         q_se   <= '0;
         q_tot  <= '0;
      end else if (load1_i) begin
         q_disp <= r_disp;
         q_ss   <= c_ss;
         q_se   <= c_se;
         q_tot  <= t_hi;
      end
   end

   // ---------------- stage 2: sync pulse placement and length
   mlc_val_t se_a, ss_b, se_c;

   always_comb begin
      se_a = cap_hi(q_se, sat_sub(q_tot, K_SEGAP));
      ss_b = cap_lo(q_ss, q_disp + K_SSGAP);
      se_c = cap_hi(se_a, ss_b + K_SLEN);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         disp_o <= '0;
         ss_o   <= '0;
         se_o   <= '0;
         tot_o  <= '0;
      end else if (load2_i) begin
         disp_o <= q_disp;
         ss_o   <= ss_b;
         se_o   <= se_c;
         tot_o  <= q_tot;
      end
   end

   // ---------------- assertions
   // R2 R5
   disp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load2_i |=> (disp_o >= K_DMIN && disp_o <= K_DMAX));

   // R3 R6
   tot_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load2_i |=> (tot_o >= disp_o + K_TLO && tot_o <= disp_o + K_THI));

   // R4 R7
   sync_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load2_i |=> (ss_o >= disp_o + K_SSGAP && se_o <= ss_o + K_SLEN));

   // R9
   out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load2_i |=> ($stable(disp_o) && $stable(ss_o) && $stable(se_o) && $stable(tot_o)));

   if (ALIGN_BITS > 0) begin : gen_align_chk
      // R1
      grid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         load2_i |=> (((disp_o | ss_o | se_o | tot_o) & LOW_MASK) == '0));
   end

endmodule

// File: rtl/modeline_clamp.sv
`timescale 1ns/1ps
module modeline_clamp
   import mlc_pkg::*;
#(
   parameter int unsigned H_ALIGN_BITS = 3,
   parameter int unsigned H_FIELD_MAX  = 'h1FF,
   parameter int unsigned H_TOT_EXTRA  = 5,
   parameter int unsigned H_DISP_MIN   = 640,
   parameter int unsigned H_DISP_MAX   = 2048,
   parameter int unsigned H_BLANK_MIN  = 80,
   parameter int unsigned H_BLANK_MAX  = 'h3F8,
   parameter int unsigned H_SYNC_LEN   = 'hF8,
   parameter int unsigned V_FIELD_MAX  = 'h7FF,
   parameter int unsigned V_TOT_EXTRA  = 2,
   parameter int unsigned V_DISP_MIN   = 480,
   parameter int unsigned V_DISP_MAX   = 1536,
   parameter int unsigned V_BLANK_MIN  = 3,
   parameter int unsigned V_BLANK_MAX  = 'hFF,
   parameter int unsigned V_SYNC_LEN   = 'hF
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        valid_i,
   input  logic [15:0] h_disp_i,
   input  logic [15:0] h_ss_i,
   input  logic [15:0] h_se_i,
   input  logic [15:0] h_tot_i,
   input  logic [15:0] v_disp_i,
   input  logic [15:0] v_ss_i,
   input  logic [15:0] v_se_i,
   input  logic [15:0] v_tot_i,
   output logic [15:0] h_disp_o,
   output logic [15:0] h_ss_o,
   output logic [15:0] h_se_o,
   output logic [15:0] h_tot_o,
   output logic [15:0] v_disp_o,
   output logic [15:0] v_ss_o,
   output logic [15:0] v_se_o,
   output logic [15:0] v_tot_o,
   output logic        done_o
);

   localparam int unsigned H_UNIT = 1 << H_ALIGN_BITS;
   localparam int unsigned V_UNIT = 1;
   localparam int unsigned LAT    = 2;

   if (MLC_W != 16) begin : gen_bad_w
      $error("modeline_clamp: port width assumes 16-bit values");
   end

   logic [LAT-1:0] taps;

   mlc_strobe_pipe #(.LAT(LAT)) u_pipe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (valid_i),
      .taps_o   (taps)
   );

   assign done_o = taps[LAT-1];

   mlc_axis_clamp #(
      .ALIGN_BITS   (H_ALIGN_BITS),
      .DISP_CAP     ((H_FIELD_MAX - 2) * H_UNIT),
      .SS_CAP       ((H_FIELD_MAX - 1) * H_UNIT),
      .SE_CAP       (H_FIELD_MAX * H_UNIT),
      .TOT_CAP      ((H_FIELD_MAX + H_TOT_EXTRA) * H_UNIT),
      .DISP_MIN     (H_DISP_MIN),
      .DISP_MAX     (H_DISP_MAX),
      .TOT_MIN_GAP  (H_BLANK_MIN),
      .TOT_MAX_GAP  (H_BLANK_MAX),
      .SE_TOT_GAP   (H_UNIT),
      .SS_DISP_GAP  (H_UNIT),
      .SYNC_MAX_LEN (H_SYNC_LEN)
   ) u_hor (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load1_i (valid_i),
      .load2_i (taps[0]),
      .disp_i  (h_disp_i),
      .ss_i    (h_ss_i),
      .se_i    (h_se_i),
      .tot_i   (h_tot_i),
      .disp_o  (h_disp_o),
      .ss_o    (h_ss_o),
      .se_o    (h_se_o),
      .tot_o   (h_tot_o)
   );

   mlc_axis_clamp #(
      .ALIGN_BITS   (0),
      .DISP_CAP     (V_FIELD_MAX - 2),
      .SS_CAP       (V_FIELD_MAX - 1),
      .SE_CAP       (V_FIELD_MAX),
      .TOT_CAP      (V_FIELD_MAX + V_TOT_EXTRA),
      .DISP_MIN     (V_DISP_MIN),
      .DISP_MAX     (V_DISP_MAX),
      .TOT_MIN_GAP  (V_BLANK_MIN),
      .TOT_MAX_GAP  (V_BLANK_MAX),
      .SE_TOT_GAP   (V_UNIT),
      .SS_DISP_GAP  (V_UNIT),
      .SYNC_MAX_LEN (V_SYNC_LEN)
   ) u_ver (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load1_i (valid_i),
      .load2_i (taps[0]),
      .disp_i  (v_disp_i),
      .ss_i    (v_ss_i),
      .se_i    (v_se_i),
      .tot_i   (v_tot_i),
      .disp_o  (v_disp_o),
      .ss_o    (v_ss_o),
      .se_o    (v_se_o),
      .tot_o   (v_tot_o)
   );

   // R8
   done_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> ##1 done_o);

   // R8
   done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(valid_i, 2));

endmodule

// File: tb/modeline_clamp_tb.sv
`timescale 1ns/1ps
module modeline_clamp_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [15:0] hd, hs, he, ht, vd, vs, ve, vt;
   logic [15:0] ohd, ohs, ohe, oht, ovd, ovs, ove, ovt;
   logic        done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   modeline_clamp dut_i (
      .clk_i (clk), .rst_ni (rst_n), .valid_i (valid),
      .h_disp_i (hd), .h_ss_i (hs), .h_se_i (he), .h_tot_i (ht),
      .v_disp_i (vd), .v_ss_i (vs), .v_se_i (ve), .v_tot_i (vt),
      .h_disp_o (ohd), .h_ss_o (ohs), .h_se_o (ohe), .h_tot_o (oht),
      .v_disp_o (ovd), .v_ss_o (ovs), .v_se_o (ove), .v_tot_o (ovt),
      .done_o (done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lim_hi(input int v, input int l);
      return (v > l) ? l : v;
   endfunction
   function automatic int lim_lo(input int v, input int l);
      return (v < l) ? l : v;
   endfunction

   // horizontal reference, returns {disp, ss, se, tot}
   function automatic logic [63:0] h_model(input int d0, input int s0, input int e0, input int t0);
      int d, s, e, t;
      d = lim_hi(d0 & 'hFFF8, 4072);
      s = lim_hi(s0 & 'hFFF8, 4080);
      e = lim_hi(e0 & 'hFFF8, 4088);
      t = lim_hi(t0 & 'hFFF8, 4128);
      d = lim_hi(lim_lo(d, 640), 2048);
      t = lim_hi(lim_lo(t, d + 80), d + 1016);
      e = lim_hi(e, (t >= 8) ? t - 8 : 0);
      s = lim_lo(s, d + 8);
      e = lim_hi(e, s + 248);
      return {d[15:0], s[15:0], e[15:0], t[15:0]};
   endfunction

   function automatic logic [63:0] v_model(input int d0, input int s0, input int e0, input int t0);
      int d, s, e, t;
      d = lim_hi(d0, 2045);
      s = lim_hi(s0, 2046);
      e = lim_hi(e0, 2047);
      t = lim_hi(t0, 2049);
      d = lim_hi(lim_lo(d, 480), 1536);
      t = lim_hi(lim_lo(t, d + 3), d + 255);
      e = lim_hi(e, (t >= 1) ? t - 1 : 0);
      s = lim_lo(s, d + 1);
      e = lim_hi(e, s + 15);
      return {d[15:0], s[15:0], e[15:0], t[15:0]};
   endfunction

   task automatic scramble();
      hd = 16'($urandom); hs = 16'($urandom); he = 16'($urandom); ht = 16'($urandom);
      vd = 16'($urandom); vs = 16'($urandom); ve = 16'($urandom); vt = 16'($urandom);
   endtask

   task automatic run_vec(input logic [15:0] a0, a1, a2, a3, b0, b1, b2, b3);
      logic [63:0] he_x, ve_x;
      logic [127:0] snap;
      he_x = h_model(int'(a0), int'(a1), int'(a2), int'(a3));
      ve_x = v_model(int'(b0), int'(b1), int'(b2), int'(b3));
      @(negedge clk);
      hd = a0; hs = a1; he = a2; ht = a3;
      vd = b0; vs = b1; ve = b2; vt = b3;
      valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
      scramble();
      chk("R8 done low after first edge", int'(done), 0);
      @(negedge clk);
      chk("R8 done high after second edge", int'(done), 1);
      chk("R2 h_disp", int'(ohd), int'(he_x[63:48]));
      chk("R4 h_ss",   int'(ohs), int'(he_x[47:32]));
      chk("R4 h_se",   int'(ohe), int'(he_x[31:16]));
      chk("R3 h_tot",  int'(oht), int'(he_x[15:0]));
      chk("R1 h low bits", int'((ohd | ohs | ohe | oht) & 16'h7), 0);
      chk("R5 v_disp", int'(ovd), int'(ve_x[63:48]));
      chk("R7 v_ss",   int'(ovs), int'(ve_x[47:32]));
      chk("R7 v_se",   int'(ove), int'(ve_x[31:16]));
      chk("R6 v_tot",  int'(ovt), int'(ve_x[15:0]));
      snap = {ohd, ohs, ohe, oht, ovd, ovs, ove, ovt};
      scramble();
      @(negedge clk);
      chk("R8 done single pulse", int'(done), 0);
      chk("R9 outputs held", int'({ohd, ohs, ohe, oht, ovd, ovs, ove, ovt} == snap), 1);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      scramble();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 outputs zero in reset",
          int'({ohd, ohs, ohe, oht, ovd, ovs, ove, ovt} == 128'd0), 1);
      chk("R10 done low in reset", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 outputs zero after reset",
          int'({ohd, ohs, ohe, oht, ovd, ovs, ove, ovt} == 128'd0), 1);
      chk("R10 done low after reset", int'(done), 0);

      // directed corners
      run_vec(16'd1024, 16'd1048, 16'd1184, 16'd1344, 16'd768, 16'd771, 16'd777, 16'd806);
      run_vec(16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0);
      run_vec(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
      run_vec(16'd1283, 16'd1290, 16'd1900, 16'd1700, 16'd1000, 16'd1001, 16'd1100, 16'd1200);
      run_vec(16'd800, 16'd700, 16'd760, 16'd810, 16'd600, 16'd500, 16'd540, 16'd590);
      run_vec(16'd2048, 16'd2050, 16'd4095, 16'd4200, 16'd1536, 16'd1540, 16'd2100, 16'd2100);
      run_vec(16'd639, 16'd4095, 16'd4095, 16'd700, 16'd479, 16'd2046, 16'd2047, 16'd482);

      // random: full range and near-legal modelines
      for (int i = 0; i < 240; i++) begin
         if (i % 2 == 0) begin
            run_vec(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                    16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
         end else begin
            int d, s, e, t, vd0, vs0, ve0, vt0;
            d   = 400 + int'($urandom % 1800);
            s   = d - 16 + int'($urandom % 300);
            e   = s + int'($urandom % 400);
            t   = d + int'($urandom % 1200);
            vd0 = 300 + int'($urandom % 1400);
            vs0 = vd0 - 2 + int'($urandom % 20);
            ve0 = vs0 + int'($urandom % 30);
            vt0 = vd0 + int'($urandom % 300);
            run_vec(16'(d), 16'(s), 16'(e), 16'(t), 16'(vd0), 16'(vs0), 16'(ve0), 16'(vt0));
         end
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule